// File: doc/BRIEF.md
# Block-Cipher Chaining Value Updater

This block holds the 128-bit chaining value of a block-cipher accelerator and works out its next value each time the cipher core finishes a 16-byte block. The cipher core sits outside: it reports completion with a one-cycle strobe and presents the block it consumed and the block it produced. From these, the selected chaining mode and the direction, the block chooses the value the register keeps for the next block.

The feedback modes (CBC and CFB-128) keep the ciphertext, whichever side of the core it appears on. ECB never reads the chaining value, yet the register still follows the core's output. In that mode, that output is the ciphertext when encrypting and the recovered plaintext when decrypting. In counter mode the register is a big-endian number, and only a selectable low slice of it counts. That slice wraps inside itself and leaves the upper bytes untouched. The host may read the register at any time and may overwrite it at any time.

Top module: `ivu_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register becomes all zeros.
- R2: A cycle with `host_wr_i` high loads `host_wdata_i` into the register, in any mode and at any time, and `iv_o` shows it from the next cycle.
- R3: When `host_wr_i` and `blk_done_i` are high in the same cycle, the host value is stored and the block update is dropped.
- R4: In a cycle with neither `host_wr_i` nor `blk_done_i`, the register keeps its value, whatever the other inputs do.
- R5: Mode codes are 0 ECB, 1 CBC, 2 CFB-128, 3 counter. `decrypt_i` = 1 selects decryption. In CBC and CFB-128, a block-done stores the ciphertext: `blk_out_i` when encrypting and `blk_in_i` when decrypting.
- R6: In ECB encryption, a block-done stores `blk_out_i` (the ciphertext), although ECB does not use the chaining value.
- R7: In ECB decryption, a block-done stores `blk_out_i` (the plaintext), not the ciphertext on `blk_in_i`.
- R8: In counter mode, a block-done adds one to the counter slice. Byte 0 (bits 127:120) is most significant, and byte 15 (bits 7:0) is least significant. Direction has no effect.
- R9: `ctr_sel_i` picks the counter slice: 0 gives the low 16 bits, 1 gives 32, 2 gives 64, 3 gives 96, and 4 to 7 give all 128. Bits above the slice never change on a counter step. An all-ones slice wraps to zero without any carry into them.
- R10: With the 128-bit setting, an all-ones register steps to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Chaining mode: 0 ECB, 1 CBC, 2 CFB-128, 3 counter |
| decrypt_i | input | 1 | 1 = decryption, 0 = encryption |
| ctr_sel_i | input | 3 | Counter slice width select |
| blk_in_i | input | 128 | Block fed into the cipher core |
| blk_out_i | input | 128 | Block produced by the cipher core |
| blk_done_i | input | 1 | One-cycle strobe: the core finished a block |
| host_wr_i | input | 1 | Host write enable for the chaining value |
| host_wdata_i | input | 128 | Host write data |
| iv_o | output | 128 | Current chaining value, readable by the host |

## Verification
A host write and a block-done strobe can land in the same cycle. This is the interaction that matters most. The bench provokes the collision on purpose in every mode, and also lets the random mix raise both strobes together. A collision passes only when the register holds exactly the host data one cycle later, with no trace of the block update. Counter steps are aimed at the wrap points: the host first loads values whose low slice is all ones at each width, and the bench then confirms that the slice clears while the bytes above it keep their value.

// File: rtl/ivu_pkg.sv
// Package: shared types for the chaining value updater.
// Assumes a 128-bit cipher block; the mode encoding is fixed by the brief.
package ivu_pkg;
    localparam int BLK_W  = 128;
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        MODE_ECB = 2'd0,
        MODE_CBC = 2'd1,
        MODE_CFB = 2'd2,
        MODE_CTR = 2'd3
    } mode_e;
endpackage

// File: rtl/ivu_ctr_mask.sv
// Counter slice mask: turns the width select into a byte-granular mask
// over the low-order bytes of the chaining value.
// Assumes BLK_W is a multiple of 8 and at least 96 bits.
module ivu_ctr_mask #(
    parameter int BLK_W = 128,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [BLK_W-1:0] mask_o
);
    localparam int NB  = BLK_W / 8;
    localparam int CNW = $clog2(NB) + 1;

    logic [CNW-1:0] nbytes;

    // Decode the select into a count of low-order counter bytes.
    always_comb begin
        case (sel_i)
            3'd0:    nbytes = CNW'(2);
            3'd1:    nbytes = CNW'(4);
            3'd2:    nbytes = CNW'(8);
            3'd3:    nbytes = CNW'(12);
            default: nbytes = CNW'(NB);
        endcase
    end

    // One mask byte per register byte, set when it lies inside the slice.
    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam logic [CNW-1:0] BIDX = CNW'(b);
        assign mask_o[b*8 +: 8] = {8{BIDX < nbytes}};
    end
endmodule

// File: rtl/ivu_ctr_inc.sv
// Masked increment: adds one to the register, keeps the result only inside
// the mask, and so wraps the slice without disturbing the bits above it.
// Assumes the mask is contiguous from bit 0 (as ivu_ctr_mask makes it).
module ivu_ctr_inc #(
    parameter int BLK_W = 128
) (
    input  logic [BLK_W-1:0] cur_i,
    input  logic [BLK_W-1:0] mask_i,
    output logic [BLK_W-1:0] nxt_o
);
    logic [BLK_W-1:0] plus_one;

    // Full-width sum; bits above the slice are taken from the old value.
    always_comb begin
        plus_one = cur_i + BLK_W'(1);
        nxt_o    = (cur_i & ~mask_i) | (plus_one & mask_i);
    end
endmodule

// File: rtl/ivu_next_sel.sv
// Next-value selector: picks the candidate chaining value for a finished
// block from the mode and the direction.
// Assumes blk_out_i is the cipher core's result for the same block.
module ivu_next_sel
    import ivu_pkg::*;
#(
    parameter int BLK_W = 128
) (
    input  mode_e            mode_i,
    input  logic             decrypt_i,
    input  logic [BLK_W-1:0] blk_in_i,
    input  logic [BLK_W-1:0] blk_out_i,
    input  logic [BLK_W-1:0] ctr_nxt_i,
    output logic [BLK_W-1:0] nxt_o
);
    // Feedback modes keep ciphertext; ECB keeps the core output; CTR counts.
    always_comb begin
        case (mode_i)
            MODE_CBC, MODE_CFB: nxt_o = decrypt_i ? blk_in_i : blk_out_i;
            MODE_CTR:           nxt_o = ctr_nxt_i;
            default:            nxt_o = blk_out_i;
        endcase
    end
endmodule

// File: rtl/ivu_top.sv
// Chaining value updater top: holds the chaining register, applies host
// writes (highest priority) and block-done updates.
// Assumes blk_done_i is a single-cycle strobe from the cipher core.
module ivu_top
    import ivu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic               decrypt_i,
    input  logic [SEL_W-1:0]   ctr_sel_i,
    input  logic [BLK_W-1:0]   blk_in_i,
    input  logic [BLK_W-1:0]   blk_out_i,
    input  logic               blk_done_i,
    input  logic               host_wr_i,
    input  logic [BLK_W-1:0]   host_wdata_i,
    output logic [BLK_W-1:0]   iv_o
);
    mode_e            mode;
    logic [BLK_W-1:0] iv_q;
    logic [BLK_W-1:0] ctr_mask;
    logic [BLK_W-1:0] ctr_nxt;
    logic [BLK_W-1:0] upd_nxt;

    assign mode = mode_e'(mode_i);

    ivu_ctr_mask #(.BLK_W(BLK_W), .SEL_W(SEL_W)) u_mask (
        .sel_i  (ctr_sel_i),
        .mask_o (ctr_mask)
    );

    ivu_ctr_inc #(.BLK_W(BLK_W)) u_inc (
        .cur_i  (iv_q),
        .mask_i (ctr_mask),
        .nxt_o  (ctr_nxt)
    );

    ivu_next_sel #(.BLK_W(BLK_W)) u_sel (
        .mode_i    (mode),
        .decrypt_i (decrypt_i),
        .blk_in_i  (blk_in_i),
        .blk_out_i (blk_out_i),
        .ctr_nxt_i (ctr_nxt),
        .nxt_o     (upd_nxt)
    );

    // Chaining register: reset, then host write, then block update.
    always_ff @(posedge clk) begin
        if (!rst_n)          iv_q <= '0;
        else if (host_wr_i)  iv_q <= host_wdata_i;
        else if (blk_done_i) iv_q <= upd_nxt;
    end

    assign iv_o = iv_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> iv_q == '0);

    // R2 (and R3: the write wins even with blk_done_i high)
    host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_i |=> iv_q == $past(host_wdata_i));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr_i && !blk_done_i) |=> $stable(iv_q));

    // R5
    fb_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done_i && !host_wr_i && decrypt_i &&
         (mode == MODE_CBC || mode == MODE_CFB)) |=> iv_q == $past(blk_in_i));

    // R6 R7
    ecb_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done_i && !host_wr_i && mode == MODE_ECB) |=> iv_q == $past(blk_out_i));

    // R9
    ctr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done_i && !host_wr_i && mode == MODE_CTR)
        |=> ((iv_q ^ $past(iv_q)) & ~$past(ctr_mask)) == '0);
endmodule

// File: tb/ivu_top_bench.sv
module ivu_top_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         dec = 1'b0;
    logic [2:0]   sel = 3'd0;
    logic [127:0] bin = '0;
    logic [127:0] bout = '0;
    logic         done = 1'b0;
    logic         wr = 1'b0;
    logic [127:0] wdata = '0;
    logic [127:0] iv;

    int checks = 0;
    int errors = 0;
    logic [127:0] exp_iv = '0;

    always #10 clk = ~clk;

    ivu_top u_ivu_top (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .decrypt_i(dec),
        .ctr_sel_i(sel), .blk_in_i(bin), .blk_out_i(bout),
        .blk_done_i(done), .host_wr_i(wr), .host_wdata_i(wdata), .iv_o(iv)
    );

    function automatic int slice_bytes(input logic [2:0] s);
        case (s)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            default: return 16;
        endcase
    endfunction

    // Byte-ripple big-endian increment over the low slice (R8 R9 R10).
    function automatic logic [127:0] ctr_step(input logic [127:0] c, input logic [2:0] s);
        logic [127:0] r = c;
        logic carry = 1'b1;
        for (int k = 0; k < slice_bytes(s); k++) begin
            logic [8:0] t = {1'b0, r[k*8 +: 8]} + {8'd0, carry};
            r[k*8 +: 8] = t[7:0];
            carry = t[8];
        end
        return r;
    endfunction

    function automatic logic [127:0] model(input logic [127:0] c);
        if (!rst_n) return '0;
        if (wr) return wdata;
        if (!done) return c;
        case (mode)
            2'd1, 2'd2: return dec ? bin : bout;
            2'd3:       return ctr_step(c, sel);
            default:    return bout;
        endcase
    endfunction

    function automatic string tag();
        if (!rst_n) return "R1";
        if (wr && done) return "R3";
        if (wr) return "R2";
        if (!done) return "R4";
        case (mode)
            2'd0: return dec ? "R7" : "R6";
            2'd3: return (slice_bytes(sel) == 16) ? "R10" : "R8/R9";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Inputs already set at a falling edge; check one cycle later.
    task automatic step();
        string t = tag();
        exp_iv = model(exp_iv);
        @(negedge clk);
        checks++;
        if (iv !== exp_iv) begin
            errors++;
            $display("FAIL %s: iv=%h expected=%h", t, iv, exp_iv);
        end
    endtask

    task automatic set(input logic [1:0] m, input logic d, input logic [2:0] s,
                       input logic dn, input logic w, input logic [127:0] wd);
        mode = m; dec = d; sel = s; done = dn; wr = w; wdata = wd;
        bin = rnd128(); bout = rnd128();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: iv=%h expected=%h", iv, exp_iv);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        step(); step();                       // R1 reset state
        rst_n = 1'b1;
        // R2 write then R4 hold with noisy inputs
        set(2'd1, 0, 3'd0, 0, 1, 128'h0123456789abcdef0011223344556677); step();
        set(2'd3, 1, 3'd4, 0, 0, rnd128()); step();
        // R6 R7 ECB both directions, R5 feedback modes both directions
        set(2'd0, 0, 3'd0, 1, 0, '0); step();
        set(2'd0, 1, 3'd0, 1, 0, '0); step();
        set(2'd1, 0, 3'd0, 1, 0, '0); step();
        set(2'd1, 1, 3'd0, 1, 0, '0); step();
        set(2'd2, 0, 3'd0, 1, 0, '0); step();
        set(2'd2, 1, 3'd0, 1, 0, '0); step();
        // R9 wrap at every width, R10 full wrap
        for (int s = 0; s < 8; s++) begin
            logic [127:0] base = rnd128();
            for (int k = 0; k < slice_bytes(3'(s)); k++) base[k*8 +: 8] = 8'hff;
            set(2'd3, 0, 3'(s), 0, 1, base); step();
            set(2'd3, 1, 3'(s), 1, 0, '0); step();
            set(2'd3, 0, 3'(s), 1, 0, '0); step();
        end
        set(2'd3, 0, 3'd4, 0, 1, '1); step();
        set(2'd3, 0, 3'd4, 1, 0, '0); step();
        // R3 collisions in every mode
        for (int m = 0; m < 4; m++) begin
            set(2'(m), 1'($urandom), 3'($urandom), 1, 1, rnd128()); step();
        end
        // R1 reset from a non-zero value
        set(2'd0, 0, 3'd0, 0, 1, rnd128()); step();
        rst_n = 1'b0; set(2'd1, 0, 3'd0, 1, 1, rnd128()); step();
        rst_n = 1'b1;
        // Random mix, near-wrap writes included
        for (int i = 0; i < 3000; i++) begin
            logic [127:0] wd = rnd128();
            logic [2:0] s = 3'($urandom);
            if ($urandom % 2 == 0)
                for (int k = 0; k < slice_bytes(s); k++) wd[k*8 +: 8] = 8'hff;
            set(2'($urandom), 1'($urandom), s, ($urandom % 3) != 0,
                ($urandom % 5) == 0, wd);
            step();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule